// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block picks one operation per clock from a pool of hardware thread contexts. Many streams run at once, so a long memory latency stays hidden. Each stream offers an operation on a per-stream valid/grant handshake. On any cycle the scheduler grants at most one stream, using round-robin order. A granted memory operation receives a reference tag from that stream's own slot set. The reference then goes out on the memory request port. If memory refuses it, it enters a retry pool and is resent later, and the stream that made it is not involved again. A blocking memory operation (a load whose data the stream needs) puts its stream to sleep. The stream wakes when the response carrying that reference's tag comes back.

Back-pressure rules: a stream holds `op_valid` and its operation attributes until it sees its `op_grant` bit high in the same cycle. `op_grant` depends only on registered state and on this cycle's `op_valid`/`op_mem`. On the memory side, `mreq_valid` with `mreq_accept` low counts as a refusal, and the scheduler keeps the reference. The memory side must accept responses every cycle, one per cycle. A response may come back any number of cycles after its request was accepted.

Top module: `stream_issue_sched`

## Requirements
- R1: After reset no stream is granted until its `op_valid` is high. No reference is outstanding, every stream's slots are all free (its first memory operation gets tag 0), and the retry pool is empty, so the first request on the memory port has `mreq_retry` low.
- R2: `op_grant` has at most one bit set, and only for a stream whose `op_valid` is high. `issue_valid` is high with `issue_sid` equal to the granted index, or low with `op_grant` zero.
- R3: Among eligible streams, the grant goes to the first one found by scanning upward (with wrap-around) from the stream after the one granted last. After reset, the scan starts at stream 0.
- R4: A grant can go to a different stream on every consecutive cycle, with no idle cycle between switches. Whenever any stream is eligible, some stream is granted.
- R5: A stream with MAX_OUT references outstanding is not eligible for a memory operation (`op_mem` high). It stays eligible for a non-memory operation.
- R6: A granted memory operation gets `issue_tag` equal to the lowest-numbered free slot of its stream. A response (`mrsp_sid`, `mrsp_tag`) frees that slot from the next cycle on.
- R7: A granted memory operation with `op_blk` high stalls its stream: the stream is not granted from the next cycle on. Only a response whose tag matches the blocking reference clears the stall, and it takes effect from the cycle after that response. Responses with other tags leave the stall in place.
- R8: While the retry pool holds entries, the memory port carries the oldest entry with `mreq_retry` high. A new memory operation granted in that cycle is appended to the pool instead.
- R9: A new reference refused by memory is appended to the pool. A refused retry stays at the head of the pool. An accepted retry leaves the pool. References leave the pool in the order they entered it.
- R10: When the retry pool is full, no stream is eligible for a memory operation. Non-memory operations are still granted.
- R11: A reference keeps its slot until its response arrives, however long that takes. No reference is dropped or timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | NUM_STREAMS | Per-stream: an operation is offered |
| op_mem | input | NUM_STREAMS | Per-stream: the offered operation is a memory reference |
| op_blk | input | NUM_STREAMS | Per-stream: the memory reference is blocking (the stream waits for its data) |
| op_grant | output | NUM_STREAMS | Per-stream grant; the offered operation is taken this cycle |
| issue_valid | output | 1 | An operation issues this cycle |
| issue_sid | output | SW | Index of the issuing stream |
| issue_mem | output | 1 | The issuing operation is a memory reference |
| issue_tag | output | TW | Slot tag given to the issuing memory reference |
| mreq_valid | output | 1 | Memory request present |
| mreq_sid | output | SW | Stream of the request |
| mreq_tag | output | TW | Tag of the request |
| mreq_retry | output | 1 | The request comes from the retry pool |
| mreq_accept | input | 1 | Memory takes the request this cycle; low with `mreq_valid` means refused |
| mrsp_valid | input | 1 | Memory response present |
| mrsp_sid | input | SW | Stream of the response |
| mrsp_tag | input | TW | Tag of the response |

## Verification
The grant, issue and memory request outputs are combinational from registered state and the current inputs, so they are due in the same cycle as the stimulus. Their effects on state are due one cycle later: slot use, stalls, round-robin position and the pool contents all appear after the next rising edge. The bench applies inputs just after the falling edge and samples all outputs 1 ns later. It compares them with a bench model whose state it advances only at the rising edge, using the very inputs it applied. Because of this, a response or refusal in cycle N changes the expected grant in cycle N+1, never in cycle N.

// File: rtl/sis_pkg.sv
package sis_pkg;
  // width of an index into n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sis_stream_ctx.sv
module sis_stream_ctx #(
  parameter int MAX_OUT = 8,
  parameter int TAG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             alloc_blk,
  input  logic             rel,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             full,
  output logic [TAG_W-1:0] free_tag,
  output logic             stalled
);
  logic [MAX_OUT-1:0] busy, busy_n;
  logic [TAG_W-1:0]   wait_tag;

  // lowest free slot
  always_comb begin
    free_tag = '0;
    for (int s = MAX_OUT - 1; s >= 0; s--) begin
      if (!busy[s]) free_tag = TAG_W'(s);
    end
  end

  assign full = &busy;

  always_comb begin
    busy_n = busy;
    for (int s = 0; s < MAX_OUT; s++) begin
      if (rel && rel_tag == TAG_W'(s))   busy_n[s] = 1'b0;
      if (alloc && free_tag == TAG_W'(s)) busy_n[s] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= '0;
      stalled  <= 1'b0;
      wait_tag <= '0;
    end else begin
      busy <= busy_n;
      if (alloc && alloc_blk) begin
        stalled  <= 1'b1;
        wait_tag <= free_tag;
      end else if (stalled && rel && rel_tag == wait_tag) begin
        stalled <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sis_rr_pick.sv
module sis_rr_pick #(
  parameter int N = 128,
  parameter int W = 7
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] last,
  output logic [N-1:0] gnt,
  output logic [W-1:0] gid,
  output logic         any
);
  always_comb begin
    any = 1'b0;
    gid = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      logic [W-1:0] jj;
      j = int'(last) + k;
      if (j >= N) j = j - N;
      jj = W'(j);
      if (!any && req[jj]) begin
        any = 1'b1;
        gid = jj;
      end
    end
    gnt = '0;
    if (any) gnt[gid] = 1'b1;
  end
endmodule

// File: rtl/sis_retry_fifo.sv
module sis_retry_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PW = sis_pkg::idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched #(
  parameter int NUM_STREAMS = 128,
  parameter int MAX_OUT     = 8,
  parameter int RETRY_DEPTH = 16,
  localparam int SW = sis_pkg::idx_w(NUM_STREAMS),
  localparam int TW = sis_pkg::idx_w(MAX_OUT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] op_valid,
  input  logic [NUM_STREAMS-1:0] op_mem,
  input  logic [NUM_STREAMS-1:0] op_blk,
  output logic [NUM_STREAMS-1:0] op_grant,
  output logic                   issue_valid,
  output logic [SW-1:0]          issue_sid,
  output logic                   issue_mem,
  output logic [TW-1:0]          issue_tag,
  output logic                   mreq_valid,
  output logic [SW-1:0]          mreq_sid,
  output logic [TW-1:0]          mreq_tag,
  output logic                   mreq_retry,
  input  logic                   mreq_accept,
  input  logic                   mrsp_valid,
  input  logic [SW-1:0]          mrsp_sid,
  input  logic [TW-1:0]          mrsp_tag
);
  localparam int EW = SW + TW;

  logic [NUM_STREAMS-1:0] elig, ctx_full, ctx_stall;
  logic [TW-1:0]          ctx_tag [NUM_STREAMS];
  logic [SW-1:0]          last_sid;
  logic                   pool_empty, pool_full, pool_push, pool_pop;
  logic [EW-1:0]          pool_head;

  // one context per hardware stream
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_ctx
    sis_stream_ctx #(.MAX_OUT(MAX_OUT), .TAG_W(TW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (op_grant[g] & op_mem[g]),
      .alloc_blk(op_blk[g]),
      .rel      (mrsp_valid && (mrsp_sid == SW'(g))),
      .rel_tag  (mrsp_tag),
      .full     (ctx_full[g]),
      .free_tag (ctx_tag[g]),
      .stalled  (ctx_stall[g])
    );
    assign elig[g] = op_valid[g] & ~ctx_stall[g]
                   & ~(op_mem[g] & (ctx_full[g] | pool_full));
  end

  sis_rr_pick #(.N(NUM_STREAMS), .W(SW)) u_pick (
    .req (elig),
    .last(last_sid),
    .gnt (op_grant),
    .gid (issue_sid),
    .any (issue_valid)
  );

  assign issue_mem = issue_valid & op_mem[issue_sid];
  assign issue_tag = ctx_tag[issue_sid];

  // memory port: pool head first, otherwise the fresh reference
  always_comb begin
    if (!pool_empty) begin
      mreq_valid = 1'b1;
      mreq_retry = 1'b1;
      mreq_sid   = pool_head[EW-1:TW];
      mreq_tag   = pool_head[TW-1:0];
    end else begin
      mreq_valid = issue_mem;
      mreq_retry = 1'b0;
      mreq_sid   = issue_sid;
      mreq_tag   = issue_tag;
    end
  end

  assign pool_pop  = ~pool_empty & mreq_accept;
  assign pool_push = issue_mem & (~pool_empty | ~mreq_accept);

  sis_retry_fifo #(.DEPTH(RETRY_DEPTH), .DW(EW)) u_pool (
    .clk  (clk),
    .rst_n(rst_n),
    .push (pool_push),
    .din  ({issue_sid, issue_tag}),
    .pop  (pool_pop),
    .dout (pool_head),
    .empty(pool_empty),
    .full (pool_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_sid <= SW'(NUM_STREAMS - 1);
    else if (issue_valid) last_sid <= issue_sid;
  end
endmodule

// File: rtl/sis_checker.sv
module sis_checker #(
  parameter int NUM_STREAMS = 128,
  parameter int MAX_OUT     = 8,
  parameter int SW = sis_pkg::idx_w(NUM_STREAMS),
  parameter int TW = sis_pkg::idx_w(MAX_OUT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_STREAMS-1:0] op_valid,
  input logic [NUM_STREAMS-1:0] op_blk,
  input logic [NUM_STREAMS-1:0] op_grant,
  input logic                   issue_valid,
  input logic [SW-1:0]          issue_sid,
  input logic                   issue_mem,
  input logic                   mreq_valid,
  input logic [SW-1:0]          mreq_sid,
  input logic [TW-1:0]          mreq_tag,
  input logic                   mreq_retry,
  input logic                   mreq_accept,
  input logic                   mrsp_valid,
  input logic [SW-1:0]          mrsp_sid
);
  localparam int CW = $clog2(MAX_OUT + 1);

  // outstanding references per stream, seen only from the ports
  logic [CW-1:0] seen [NUM_STREAMS];
  logic          lim_bad, blk_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_STREAMS; s++) seen[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        case ({issue_mem && issue_sid == SW'(s),
               mrsp_valid && mrsp_sid == SW'(s) && seen[s] != '0})
          2'b10:   seen[s] <= seen[s] + 1'b1;
          2'b01:   seen[s] <= seen[s] - 1'b1;
          default: seen[s] <= seen[s];
        endcase
      end
    end
  end

  assign lim_bad = issue_mem && (seen[issue_sid] >= CW'(MAX_OUT));
  assign blk_now = issue_mem && op_blk[issue_sid];

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_grant));

  a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_grant & ~op_valid) == '0);

  a_r5_no_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_bad);

  a_r7_stall_next: assert property (@(posedge clk) disable iff (!rst_n)
    blk_now |=> !(issue_valid && issue_sid == $past(issue_sid)));

  a_r9_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_retry && !mreq_accept) |=>
      (mreq_valid && mreq_retry && mreq_sid == $past(mreq_sid) && mreq_tag == $past(mreq_tag)));

  a_r8_refused_to_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_retry && !mreq_accept) |=>
      (mreq_valid && mreq_retry && mreq_sid == $past(mreq_sid) && mreq_tag == $past(mreq_tag)));
endmodule

bind stream_issue_sched sis_checker #(
  .NUM_STREAMS(NUM_STREAMS),
  .MAX_OUT    (MAX_OUT)
) u_chk (.*);

// File: tb/tb_stream_issue_sched.sv
module tb_stream_issue_sched;
  localparam int NS = 4, MO = 4, RD = 4, SW = 2, TW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NS-1:0] op_valid, op_mem, op_blk, op_grant;
  logic          issue_valid, issue_mem, mreq_valid, mreq_retry, mreq_accept, mrsp_valid;
  logic [SW-1:0] issue_sid, mreq_sid, mrsp_sid;
  logic [TW-1:0] issue_tag, mreq_tag, mrsp_tag;

  stream_issue_sched #(.NUM_STREAMS(NS), .MAX_OUT(MO), .RETRY_DEPTH(RD)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mem(op_mem), .op_blk(op_blk),
    .op_grant(op_grant), .issue_valid(issue_valid), .issue_sid(issue_sid),
    .issue_mem(issue_mem), .issue_tag(issue_tag), .mreq_valid(mreq_valid),
    .mreq_sid(mreq_sid), .mreq_tag(mreq_tag), .mreq_retry(mreq_retry),
    .mreq_accept(mreq_accept), .mrsp_valid(mrsp_valid), .mrsp_sid(mrsp_sid),
    .mrsp_tag(mrsp_tag)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the scheduler state
  bit m_busy [NS][MO];
  bit m_stall [NS];
  int m_wtag [NS];
  int m_last = NS - 1;
  int pool_q[$];
  int fly_q[$];

  function automatic int free_of(int s);
    for (int t = 0; t < MO; t++) if (!m_busy[s][t]) return t;
    return -1;
  endfunction

  function automatic bit elig(int s);
    return op_valid[s] && !m_stall[s] &&
           !(op_mem[s] && (free_of(s) < 0 || pool_q.size() >= RD));
  endfunction

  function automatic int pick();
    for (int k = 1; k <= NS; k++) begin
      int j = (m_last + k) % NS;
      if (elig(j)) return j;
    end
    return -1;
  endfunction

  // one cycle: called just after a falling edge with inputs applied
  task automatic cyc(input string req);
    int g, t, ref_id;
    bit eiv, emem, emv, emr;
    int esid, etag, emsid, emtag;
    logic [15:0] act, exp_v;
    logic [NS-1:0] egnt;
    #1;
    g = pick();
    t = (g >= 0 && free_of(g) >= 0) ? free_of(g) : 0;
    eiv  = (g >= 0);
    esid = eiv ? g : 0;
    emem = eiv && op_mem[g];
    etag = emem ? t : 0;
    egnt = eiv ? NS'(1 << g) : '0;
    if (pool_q.size() > 0) begin
      emv = 1; emr = 1; emsid = pool_q[0] / MO; emtag = pool_q[0] % MO;
    end else begin
      emv = emem; emr = 0; emsid = emem ? g : 0; emtag = etag;
    end
    exp_v = {egnt, eiv, 2'(esid), emem, 2'(etag), emv, 2'(emsid), 2'(emtag), emr};
    act   = {op_grant, issue_valid, issue_valid ? issue_sid : 2'b0, issue_mem,
             issue_mem ? issue_tag : 2'b0, mreq_valid, mreq_valid ? mreq_sid : 2'b0,
             mreq_valid ? mreq_tag : 2'b0, mreq_valid & mreq_retry};
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp_v);
    end
    // advance the model with this cycle's inputs
    if (mrsp_valid) begin
      m_busy[mrsp_sid][mrsp_tag] = 0;
      if (m_stall[mrsp_sid] && m_wtag[mrsp_sid] == int'(mrsp_tag)) m_stall[mrsp_sid] = 0;
    end
    if (eiv) begin
      m_last = g;
      if (emem) begin
        m_busy[g][t] = 1;
        if (op_blk[g]) begin m_stall[g] = 1; m_wtag[g] = t; end
      end
    end
    ref_id = g * MO + t;
    if (pool_q.size() > 0) begin
      if (mreq_accept) begin fly_q.push_back(pool_q[0]); void'(pool_q.pop_front()); end
      if (emem) pool_q.push_back(ref_id);
    end else if (emem) begin
      if (mreq_accept) fly_q.push_back(ref_id);
      else pool_q.push_back(ref_id);
    end
    @(posedge clk);
    @(negedge clk);
    mrsp_valid = 0;
  endtask

  task automatic respond(input int s, input int t);
    for (int i = 0; i < fly_q.size(); i++) begin
      if (fly_q[i] == s * MO + t) begin
        fly_q.delete(i);
        break;
      end
    end
    mrsp_valid = 1; mrsp_sid = SW'(s); mrsp_tag = TW'(t);
  endtask

  task automatic respond_any();
    int i = int'($urandom % fly_q.size());
    mrsp_valid = 1; mrsp_sid = SW'(fly_q[i] / MO); mrsp_tag = TW'(fly_q[i] % MO);
    fly_q.delete(i);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: got no end of run expected end of run");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 0; op_valid = 0; op_mem = 0; op_blk = 0;
    mreq_accept = 1; mrsp_valid = 0; mrsp_sid = 0; mrsp_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: idle after reset, then first memory op gets tag 0 directly
    repeat (2) cyc("R1");
    op_valid = 4'b0001; op_mem = 4'b0001;
    cyc("R1");
    op_valid = 0; respond(0, 0);
    cyc("R6");

    // R3 R4: all streams busy with plain operations
    op_valid = 4'hF; op_mem = 0;
    repeat (6) cyc("R3 R4");

    // R5 R6: fill stream 1 slots, then free one
    op_valid = 4'b0010; op_mem = 4'b0010;
    repeat (6) cyc("R5");
    op_mem = 0;
    cyc("R5");
    op_mem = 4'b0010; respond(1, 2);
    cyc("R6");
    cyc("R6");

    // R11: very long wait, slot stays held
    op_valid = 0;
    repeat (1100) cyc("R11");
    respond(1, 0);
    cyc("R11");
    op_valid = 4'b0010;
    cyc("R11");
    op_valid = 0;
    while (fly_q.size() > 0) begin respond_any(); cyc("R11"); end

    // R7: blocking reference and tag-matched wake-up
    op_valid = 4'b0100; op_mem = 4'b0100; op_blk = 0;
    cyc("R7");
    op_blk = 4'b0100;
    cyc("R7");
    repeat (3) cyc("R7");
    respond(2, 0);
    cyc("R7");
    cyc("R7");
    respond(2, 1);
    cyc("R7");
    cyc("R7");
    op_valid = 0; op_blk = 0;
    while (fly_q.size() > 0) begin respond_any(); cyc("R7"); end
    cyc("R7");

    // R8 R9 R10: refusals fill the pool
    mreq_accept = 0; op_valid = 4'b1001; op_mem = 4'b1001;
    repeat (6) cyc("R8 R9");
    op_valid = 4'b1011;
    repeat (2) cyc("R10");
    mreq_accept = 1;
    repeat (6) cyc("R9");
    op_valid = 0;
    repeat (6) cyc("R9");
    while (fly_q.size() > 0) begin respond_any(); cyc("R9"); end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      op_valid = NS'($urandom); op_mem = NS'($urandom);
      op_blk = NS'($urandom & $urandom);
      mreq_accept = ($urandom % 10) < 7;
      if (fly_q.size() > 0 && ($urandom % 2) == 1) respond_any();
      cyc("R2 R3 R5 R7 R8 R9");
    end
    op_valid = 0; mreq_accept = 1;
    for (int n = 0; n < 300 && (fly_q.size() > 0 || pool_q.size() > 0); n++) begin
      if (fly_q.size() > 0) respond_any();
      cyc("R9 R11");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule